// File: doc/BRIEF.md
# Timer Compare Output Channel

This block is one channel of a general-purpose timer, used in output-compare mode. It watches the live counter value and the count direction that the timer core supplies. It compares the counter against a programmable compare value and produces the channel's output waveform. A 3-bit mode field selects the waveform:

- disconnected
- set, clear or toggle on a compare match
- forced low or forced high
- two PWM polarities, whose level rule changes with the count direction

The compare value can be written directly. It can instead be staged in a shadow register, which is copied across only on a counter update event. An immediate-output option lets a trigger event act as a match. An external clear input, when enabled, forces the waveform low. A software strobe produces a channel event that behaves exactly like a hardware match.

Configuration comes in through a byte-wide write port. The compare value comes in through a separate word-wide write port. The timer core provides single-cycle event strobes.

Top module: `tmr_oc_channel`

## Requirements
- R1: After reset, `ch_out` is 0, `cmp_live` is 0, and the configuration byte reads as all zeros (mode 000, output direction, every option off).
- R2: With mode code 000 (disconnected), `ch_out` stays 0 whatever the counter, the events or the internal waveform do.
- R3: Mode 001 drives the waveform to 1, and mode 010 drives it to 0, on the clock edge at which `cnt_val` equals the active compare value. Between matches the level holds.
- R4: Mode 011 inverts the waveform on every clock edge at which `cnt_val` equals the active compare value.
- R5: Mode 100 forces the waveform to 0 and mode 101 forces it to 1 on the next edge, whatever the counter value.
- R6: Mode 110: while counting up (`cnt_down`=0), the next level is 1 when compare > counter and 0 otherwise. While counting down, the next level is 0 when compare < counter and 1 otherwise.
- R7: Mode 111 produces the complement of the mode 110 level for the same compare value, counter value and direction.
- R8: Configuration bit 5 enables the external clear. When it is set, `ext_clr`=1 drives the waveform to 0 on the next edge, overriding every mode. When it is clear, `ext_clr` has no effect.
- R9: A one-cycle `sw_evt` pulse acts exactly like a compare match in modes 001, 010 and 011, even when the counter does not equal the compare value.
- R10: Configuration bit 3 enables buffering. When it is set, a compare write goes only to the shadow register, and `cmp_live` takes the shadow value at the edge where `upd_evt` is 1. When it is clear, a compare write appears on `cmp_live` after the next edge, and `upd_evt` has no effect.
- R11: Configuration bit 4 enables immediate output. When it is set, `trig_evt`=1 acts as a match in modes 001 to 011, and drives mode 110 to 1 and mode 111 to 0 on the next edge. When it is clear, `trig_evt` is ignored.
- R12: Configuration bits 7:6 set the channel direction. Any value other than 00 holds `ch_out` at 0 and clears the waveform.
- R13: A configuration write takes effect on the following edge. The byte layout is mode in bits 2:0, buffering in bit 3, immediate output in bit 4, external clear in bit 5 and direction in bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_val | input | CNT_W | Live counter value |
| cnt_down | input | 1 | Count direction, 1 = counting down |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration byte (layout in R13) |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_data | input | CNT_W | Compare value to write |
| upd_evt | input | 1 | Counter update/overflow event strobe |
| trig_evt | input | 1 | Trigger event strobe |
| sw_evt | input | 1 | Software channel event strobe |
| ext_clr | input | 1 | External clear level |
| ch_out | output | 1 | Channel output |
| cmp_live | output | CNT_W | Active compare value |

## Verification
The waveform register is the block's only memory of past matches. A wrong set, clear or toggle decision therefore shows on `ch_out` one edge after the offending cycle, and the error persists until the next match or forced mode. A wrong shadow/active transfer shows directly on `cmp_live` one edge after the write or update strobe. It then shows up a second time as matches and PWM edges at the wrong counter values. A reference model, compared on every clock, catches either fault on the first cycle it becomes visible.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;

    typedef enum logic [2:0] {
        OC_OFF  = 3'b000,
        OC_SET  = 3'b001,
        OC_CLR  = 3'b010,
        OC_TGL  = 3'b011,
        OC_FLO  = 3'b100,
        OC_FHI  = 3'b101,
        OC_PWMA = 3'b110,
        OC_PWMB = 3'b111
    } oc_mode_e;

    // Packed MSB first: dir[7:6], clr_en[5], imm_en[4], buf_en[3], mode[2:0]
    typedef struct packed {
        logic [1:0] dir;
        logic       clr_en;
        logic       imm_en;
        logic       buf_en;
        oc_mode_e   mode;
    } oc_cfg_t;

    localparam int CFG_W = $bits(oc_cfg_t);

    function automatic logic is_match_mode(oc_mode_e m);
        return (m == OC_SET) || (m == OC_CLR) || (m == OC_TGL);
    endfunction

endpackage

// File: rtl/tmr_oc_cmpreg.sv
module tmr_oc_cmpreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         buf_en,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         upd,
    output logic [W-1:0] active
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr) begin
                shadow_q <= wdata;
            end
            if (!buf_en) begin
                if (wr) begin
                    active_q <= wdata;
                end
            end else if (upd) begin
                active_q <= shadow_q;
            end
        end
    end

    assign active = active_q;
endmodule

// File: rtl/tmr_oc_waveform.sv
module tmr_oc_waveform
    import tmr_oc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  oc_cfg_t      cfg,
    input  logic [W-1:0] cnt_val,
    input  logic         cnt_down,
    input  logic [W-1:0] cmp_val,
    input  logic         sw_evt,
    input  logic         trig_evt,
    input  logic         ext_clr,
    output logic         raw
);
    logic raw_q;
    logic raw_d;
    logic hit;
    logic imm_fire;
    logic pwm_lvl;

    always_comb begin
        imm_fire = cfg.imm_en & trig_evt;
        hit      = (cnt_val == cmp_val) | sw_evt | imm_fire;
        // Level for polarity A; direction decides how equality resolves
        pwm_lvl  = cnt_down ? (cmp_val >= cnt_val) : (cmp_val > cnt_val);

        unique case (cfg.mode)
            OC_OFF:  raw_d = raw_q;
            OC_SET:  raw_d = hit ? 1'b1 : raw_q;
            OC_CLR:  raw_d = hit ? 1'b0 : raw_q;
            OC_TGL:  raw_d = hit ? ~raw_q : raw_q;
            OC_FLO:  raw_d = 1'b0;
            OC_FHI:  raw_d = 1'b1;
            OC_PWMA: raw_d = imm_fire ? 1'b1 : pwm_lvl;
            OC_PWMB: raw_d = imm_fire ? 1'b0 : ~pwm_lvl;
            default: raw_d = raw_q;
        endcase

        if (cfg.dir != 2'b00) begin
            raw_d = 1'b0;
        end
        if (cfg.clr_en && ext_clr) begin
            raw_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
        end else begin
            raw_q <= raw_d;
        end
    end

    assign raw = raw_q;
endmodule

// File: rtl/tmr_oc_channel.sv
module tmr_oc_channel
    import tmr_oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_data,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_data,
    input  logic             upd_evt,
    input  logic             trig_evt,
    input  logic             sw_evt,
    input  logic             ext_clr,
    output logic             ch_out,
    output logic [CNT_W-1:0] cmp_live
);
    oc_cfg_t          cfg_q;
    logic [CNT_W-1:0] cmp_act;
    logic             raw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= oc_cfg_t'(cfg_data[CFG_W-1:0]);
        end
    end

    tmr_oc_cmpreg #(.W(CNT_W)) u_cmpreg (
        .clk    (clk),
        .rst    (rst),
        .buf_en (cfg_q.buf_en),
        .wr     (cmp_wr),
        .wdata  (cmp_data),
        .upd    (upd_evt),
        .active (cmp_act)
    );

    tmr_oc_waveform #(.W(CNT_W)) u_wave (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg_q),
        .cnt_val  (cnt_val),
        .cnt_down (cnt_down),
        .cmp_val  (cmp_act),
        .sw_evt   (sw_evt),
        .trig_evt (trig_evt),
        .ext_clr  (ext_clr),
        .raw      (raw_q)
    );

    assign ch_out   = raw_q & (cfg_q.dir == 2'b00) & (cfg_q.mode != OC_OFF);
    assign cmp_live = cmp_act;
endmodule

// File: rtl/tmr_oc_checker.sv
module tmr_oc_checker
    import tmr_oc_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] cnt_val,
    input logic         sw_evt,
    input logic         trig_evt,
    input logic         ext_clr,
    input logic         upd_evt,
    input logic         cfg_wr,
    input oc_cfg_t      cfg_q,
    input logic [W-1:0] cmp_act,
    input logic         raw_q,
    input logic         ch_out
);
    logic out_dir;
    logic no_clr;
    assign out_dir = (cfg_q.dir == 2'b00);
    assign no_clr  = !(cfg_q.clr_en && ext_clr);

    p_set_on_match_r3: assert property (@(posedge clk) disable iff (rst)
        (out_dir && no_clr && cfg_q.mode == OC_SET && cnt_val == cmp_act) |=> raw_q);

    p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        (out_dir && no_clr && cfg_q.mode == OC_TGL && (cnt_val == cmp_act || sw_evt)) |=> (raw_q != $past(raw_q)));

    p_forced_high_r5: assert property (@(posedge clk) disable iff (rst)
        (out_dir && no_clr && cfg_q.mode == OC_FHI) |=> raw_q);

    p_forced_low_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == OC_FLO) |=> !raw_q);

    p_ext_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.clr_en && ext_clr) |=> !raw_q);

    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.buf_en && !upd_evt) |=> $stable(cmp_act));

    p_non_output_dir_r12: assert property (@(posedge clk) disable iff (rst)
        (!out_dir) |=> !raw_q);

    p_disconnected_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mode == OC_OFF && !cfg_wr) |=> !ch_out);

    p_imm_pwmb_r11: assert property (@(posedge clk) disable iff (rst)
        (out_dir && cfg_q.mode == OC_PWMB && cfg_q.imm_en && trig_evt) |=> !raw_q);
endmodule

bind tmr_oc_channel tmr_oc_checker #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_val  (cnt_val),
    .sw_evt   (sw_evt),
    .trig_evt (trig_evt),
    .ext_clr  (ext_clr),
    .upd_evt  (upd_evt),
    .cfg_wr   (cfg_wr),
    .cfg_q    (cfg_q),
    .cmp_act  (cmp_act),
    .raw_q    (raw_q),
    .ch_out   (ch_out)
);

// File: tb/tmr_oc_channel_bench.sv
`timescale 1ns/1ps
module tmr_oc_channel_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] cnt_val;
    logic         cnt_down;
    logic         cfg_wr;
    logic [7:0]   cfg_data;
    logic         cmp_wr;
    logic [W-1:0] cmp_data;
    logic         upd_evt;
    logic         trig_evt;
    logic         sw_evt;
    logic         ext_clr;
    logic         ch_out;
    logic [W-1:0] cmp_live;

    always #5 clk = ~clk;

    tmr_oc_channel #(.CNT_W(W)) u_tmr_oc_channel (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_down(cnt_down),
        .cfg_wr(cfg_wr), .cfg_data(cfg_data), .cmp_wr(cmp_wr), .cmp_data(cmp_data),
        .upd_evt(upd_evt), .trig_evt(trig_evt), .sw_evt(sw_evt), .ext_clr(ext_clr),
        .ch_out(ch_out), .cmp_live(cmp_live)
    );

    // Reference model state
    int m_mode, m_buf, m_imm, m_clr, m_dir;
    int m_act, m_shd, m_raw;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    string cur_req = "R1";

    function automatic logic [7:0] mk_cfg(int mode, int bufe, int imm, int clr, int dir);
        return {dir[1:0], clr[0], imm[0], bufe[0], mode[2:0]};
    endfunction

    // Behavioural next-state of the model, applied at each rising edge
    task automatic model_step();
        int hit, lvl, nraw, nact, nshd, fire;
        if (rst) begin
            m_mode = 0; m_buf = 0; m_imm = 0; m_clr = 0; m_dir = 0;
            m_act = 0; m_shd = 0; m_raw = 0;
            return;
        end
        fire = m_imm && trig_evt;
        hit  = (int'(cnt_val) == m_act) || sw_evt || fire;
        if (cnt_down) lvl = (m_act >= int'(cnt_val)) ? 1 : 0;
        else          lvl = (m_act >  int'(cnt_val)) ? 1 : 0;
        case (m_mode)
            1: nraw = hit ? 1 : m_raw;
            2: nraw = hit ? 0 : m_raw;
            3: nraw = hit ? 1 - m_raw : m_raw;
            4: nraw = 0;
            5: nraw = 1;
            6: nraw = fire ? 1 : lvl;
            7: nraw = fire ? 0 : 1 - lvl;
            default: nraw = m_raw;
        endcase
        if (m_dir != 0) nraw = 0;
        if (m_clr && ext_clr) nraw = 0;
        nshd = cmp_wr ? int'(cmp_data) : m_shd;
        nact = m_act;
        if (!m_buf) begin
            if (cmp_wr) nact = int'(cmp_data);
        end else if (upd_evt) begin
            nact = m_shd;
        end
        m_raw = nraw; m_shd = nshd; m_act = nact;
        if (cfg_wr) begin
            m_mode = cfg_data[2:0]; m_buf = cfg_data[3]; m_imm = cfg_data[4];
            m_clr = cfg_data[5]; m_dir = cfg_data[7:6];
        end
    endtask

    task automatic compare();
        int exp_out;
        exp_out = (m_raw == 1 && m_dir == 0 && m_mode != 0) ? 1 : 0;
        n_checks++;
        if (int'(ch_out) != exp_out) begin
            n_fail++;
            $display("FAIL %s ch_out actual=%0d expected=%0d t=%0t", cur_req, ch_out, exp_out, $time);
        end
        n_checks++;
        if (int'(cmp_live) != m_act) begin
            n_fail++;
            $display("FAIL %s cmp_live actual=%0d expected=%0d t=%0t", cur_req, cmp_live, m_act, $time);
        end
    endtask

    // One clock: model advances with the DUT, outputs compared at falling edge,
    // strobes cleared so the caller drives the next cycle.
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        cfg_wr = 0; cmp_wr = 0; upd_evt = 0; trig_evt = 0; sw_evt = 0;
    endtask

    task automatic set_cfg(int mode, int bufe, int imm, int clr, int dir);
        cfg_wr = 1; cfg_data = mk_cfg(mode, bufe, imm, clr, dir);
        tick();
    endtask

    task automatic set_cmp(int v);
        cmp_wr = 1; cmp_data = W'(v);
        tick();
    endtask

    task automatic sweep(int lo, int hi, bit down);
        cnt_down = down;
        for (int i = 0; i <= hi - lo; i++) begin
            cnt_val = W'(down ? hi - i : lo + i);
            tick();
        end
    endtask

    function automatic string req_of_mode(int m);
        case (m)
            0: return "R2";
            1, 2: return "R3";
            3: return "R4";
            4, 5: return "R5";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; cnt_val = '0; cnt_down = 0; cfg_wr = 0; cfg_data = '0;
        cmp_wr = 0; cmp_data = '0; upd_evt = 0; trig_evt = 0; sw_evt = 0; ext_clr = 0;
        // R1: reset state
        cur_req = "R1";
        tick(); tick();
        rst = 0;
        tick();

        // R2: disconnected mode stays low despite matches and events
        cur_req = "R2";
        set_cmp(4);
        sw_evt = 1; tick();
        sweep(0, 9, 0);

        // R3 / R13: set on match, then clear on match
        cur_req = "R3";
        set_cfg(1, 0, 0, 0, 0);
        set_cmp(6);
        sweep(0, 10, 0);
        set_cfg(2, 0, 0, 0, 0);
        sweep(0, 10, 0);
        cur_req = "R13";
        set_cfg(5, 0, 0, 0, 0);
        tick();

        // R4: toggle
        cur_req = "R4";
        set_cfg(3, 0, 0, 0, 0);
        sweep(0, 8, 0); sweep(0, 8, 0); sweep(0, 8, 1);

        // R5: forced levels
        cur_req = "R5";
        set_cfg(5, 0, 0, 0, 0); sweep(0, 7, 0);
        set_cfg(4, 0, 0, 0, 0); sweep(0, 7, 0);

        // R6: PWM A, both directions, equality corner
        cur_req = "R6";
        set_cmp(8);
        set_cfg(6, 0, 0, 0, 0);
        sweep(0, 15, 0); sweep(0, 15, 1);
        set_cmp(0); sweep(0, 3, 0); sweep(0, 3, 1);

        // R7: PWM B
        cur_req = "R7";
        set_cmp(8);
        set_cfg(7, 0, 0, 0, 0);
        sweep(0, 15, 0); sweep(0, 15, 1);

        // R8: external clear enabled, then disabled
        cur_req = "R8";
        set_cfg(5, 0, 0, 1, 0);
        ext_clr = 1; tick(); tick();
        ext_clr = 0; tick();
        set_cfg(5, 0, 0, 0, 0);
        ext_clr = 1; tick(); tick();
        ext_clr = 0; tick();

        // R9: software event acts as a match with no counter match
        cur_req = "R9";
        set_cmp(100);
        cnt_val = W'(3);
        set_cfg(3, 0, 0, 0, 0);
        sw_evt = 1; tick(); tick();
        sw_evt = 1; tick(); tick();
        set_cfg(1, 0, 0, 0, 0);
        sw_evt = 1; tick(); tick();

        // R10: buffered compare writes wait for update; unbuffered do not
        cur_req = "R10";
        set_cfg(1, 1, 0, 0, 0);
        set_cmp(20);
        tick(); tick();
        upd_evt = 1; tick();
        set_cmp(30);
        upd_evt = 1; cmp_wr = 1; cmp_data = W'(40); tick();
        upd_evt = 1; tick();
        set_cfg(1, 0, 0, 0, 0);
        upd_evt = 1; set_cmp(50);
        upd_evt = 1; tick();

        // R11: immediate output on trigger
        cur_req = "R11";
        cnt_val = W'(2);
        set_cfg(2, 0, 0, 0, 0); tick();
        set_cfg(1, 0, 0, 0, 0);
        trig_evt = 1; tick(); tick();
        set_cfg(1, 0, 1, 0, 0);
        set_cfg(2, 0, 1, 0, 0); tick();
        set_cfg(1, 0, 1, 0, 0);
        trig_evt = 1; tick(); tick();
        set_cfg(7, 0, 1, 0, 0);
        trig_evt = 1; tick(); tick();
        set_cfg(6, 0, 1, 0, 0);
        cnt_val = W'(60);
        trig_evt = 1; tick(); tick();

        // R12: non-output direction holds output low
        cur_req = "R12";
        set_cfg(5, 0, 0, 0, 1); tick();
        set_cfg(5, 0, 0, 0, 3); tick();
        set_cfg(5, 0, 0, 0, 0); tick();

        // Mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            cur_req = req_of_mode(m_mode);
            cnt_val  = W'($urandom_range(0, 15));
            cnt_down = 1'($urandom_range(0, 1));
            cmp_wr   = ($urandom_range(0, 9) == 0);
            cmp_data = W'($urandom_range(0, 15));
            upd_evt  = ($urandom_range(0, 7) == 0);
            trig_evt = ($urandom_range(0, 9) == 0);
            sw_evt   = ($urandom_range(0, 9) == 0);
            ext_clr  = ($urandom_range(0, 11) == 0);
            cfg_wr   = ($urandom_range(0, 24) == 0);
            cfg_data = 8'($urandom_range(0, 255));
            if (cfg_data[7:6] != 2'b00 && $urandom_range(0, 3) != 0) cfg_data[7:6] = 2'b00;
            tick();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule